// File: doc/BRIEF.md
# Real-Time Clock Prescaler with Error Trim

This block divides a sub-clock count source down to a once-per-period tick. With the default parameters the source is a 32768 Hz crystal, the divider is 15 bits wide, and the tick comes once a second. A signed trim lets software correct crystal error. A positive trim moves the divider forward by a number of source cycles, so the next tick comes that many cycles early. A negative trim holds the divider still for that many cycles, so the next tick comes late.

Software writes an 8-bit trim register from the bus clock domain. A toggle handshake carries the write into the count-source domain. In manual mode the trim is applied once for each accepted write. In automatic mode the trim is held and applied once every short or long period, counted in ticks. After each accepted write the block stays busy for a fixed settle window, and writes that arrive during that window are dropped. The register's count-source copy is synchronized back bit by bit for readback, so software can poll until every bit shows the new value. A count-source-domain soft reset clears the register and restarts the divider.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: The trim register is 8 bits: bits 5:0 are the magnitude in source cycles and bits 7:6 are the sign field. Readback returns the accepted value after synchronization.
- R2: With no trim applied, `tick` is a one-cycle pulse every 2^DIV_W source cycles.
- R3: Sign field 01 (add) makes the interval in which the trim is applied shorter by the magnitude.
- R4: Sign field 10 (subtract) makes the interval in which the trim is applied longer by the magnitude.
- R5: Sign fields 00 and 11 leave every interval at its nominal length.
- R6: In manual mode (`auto_en` low) each accepted write applies its trim exactly once, and the following intervals are nominal.
- R7: In automatic mode a write does not apply the trim at once. The stored trim is applied once every AUTO_SHORT ticks when `auto_sel` is 0, and once every AUTO_LONG ticks when it is 1.
- R8: `busy` rises in the bus cycle after an accepted write and stays high for at least LOCK_CYC source cycles. A write made while `busy` is high is ignored: it changes neither the register nor the tick timing.
- R9: A pulse on `sw_rst` clears the register to 00h and restarts the divider, so the next tick comes 2^DIV_W source cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| bus_rst_n | input | 1 | Active-low reset, bus domain |
| wr_en | input | 1 | One-cycle write strobe for the trim register |
| wr_data | input | 8 | Trim value: sign in [7:6], magnitude in [5:0] |
| auto_en | input | 1 | 1 selects automatic mode, 0 selects manual mode |
| auto_sel | input | 1 | Automatic period: 0 selects short, 1 selects long |
| rd_data | output | 8 | Synchronized readback of the trim register |
| busy | output | 1 | High while a write is in flight or settling |
| src_clk | input | 1 | Sub-clock count source |
| src_rst_n | input | 1 | Active-low reset, count-source domain |
| sw_rst | input | 1 | Soft reset pulse, count-source domain |
| tick | output | 1 | One-cycle divided tick |

## Verification
A trim takes effect a few source cycles after the write, because of the two-stage synchronizer and one register. The bench therefore writes just after a tick and checks the length of the interval that tick opens, measured in source cycles between tick pulses, not an absolute arrival time. `busy` is checked one bus cycle after the strobe. Readback is compared only after `busy` has fallen and the readback synchronizer has had time to settle. After a soft reset, the first tick is counted source cycle by source cycle from the release of `sw_rst`. Automatic mode is checked from a record of consecutive intervals, by the spacing between the adjusted ones.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
   localparam int REG_W = 8;
   localparam int MAG_W = 6;

   typedef enum logic [1:0] {
      TRIM_NONE = 2'b00,
      TRIM_ADD  = 2'b01,
      TRIM_SUB  = 2'b10,
      TRIM_BAD  = 2'b11
   } trim_sign_e;
endpackage

// File: rtl/rtc_trim_sync.sv
module rtc_trim_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rtc_trim_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= '0;
      end else begin
         stg_q[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            stg_q[i] <= stg_q[i-1];
         end
      end
   end

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/rtc_trim_bus.sv
module rtc_trim_bus
   import rtc_trim_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             ack_s,
   output logic             req_o,
   output logic [REG_W-1:0] data_o,
   output logic             busy_o
);
   logic             req_q;
   logic [REG_W-1:0] data_q;

   assign busy_o = req_q ^ ack_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         data_q <= '0;
      end else if (wr_en && !busy_o) begin
         req_q  <= ~req_q;
         data_q <= wr_data;
      end
   end

   assign req_o  = req_q;
   assign data_o = data_q;

   // R8: an accepted write raises busy in the next cycle
   a_r8_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !busy_o) |=> busy_o);
   // R8: while busy, the held data cannot change
   a_r8_data_held: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(data_q));
endmodule

// File: rtl/rtc_trim_ctl.sv
module rtc_trim_ctl
   import rtc_trim_pkg::*;
#(
   parameter int LOCK_CYC   = 320,
   parameter int AUTO_SHORT = 10,
   parameter int AUTO_LONG  = 60
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_rst,
   input  logic             req_s,
   input  logic [REG_W-1:0] data_i,
   input  logic             auto_en_s,
   input  logic             auto_sel_s,
   input  logic             tick_i,
   output logic             ack_o,
   output logic [REG_W-1:0] adj_o,
   output logic             apply_o,
   output logic             add_o,
   output logic             sub_o,
   output logic [MAG_W-1:0] mag_o
);
   localparam int LOCK_W = $clog2(LOCK_CYC + 1);
   localparam int PER_MAX = (AUTO_LONG > AUTO_SHORT) ? AUTO_LONG : AUTO_SHORT;
   localparam int SEC_W = $clog2(PER_MAX + 1);

   logic              req_d;
   logic              ack_q;
   logic [REG_W-1:0]  adj_q;
   logic [LOCK_W-1:0] lock_q;
   logic [SEC_W-1:0]  sec_q;
   logic              apply_q;
   logic [SEC_W-1:0]  period;
   logic              new_req;
   trim_sign_e        sign;

   assign new_req = req_s ^ req_d;
   assign period  = auto_sel_s ? SEC_W'(AUTO_LONG) : SEC_W'(AUTO_SHORT);
   assign sign    = trim_sign_e'(adj_q[REG_W-1 -: 2]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_d   <= 1'b0;
         ack_q   <= 1'b0;
         adj_q   <= '0;
         lock_q  <= '0;
         sec_q   <= '0;
         apply_q <= 1'b0;
      end else begin
         req_d   <= req_s;
         apply_q <= 1'b0;
         if (sw_rst) begin
            adj_q  <= '0;
            lock_q <= '0;
            ack_q  <= req_s;
            sec_q  <= '0;
         end else begin
            if (new_req && lock_q == '0) begin
               adj_q   <= data_i;
               lock_q  <= LOCK_W'(LOCK_CYC);
               apply_q <= !auto_en_s;
            end else if (lock_q != '0) begin
               lock_q <= lock_q - LOCK_W'(1);
               if (lock_q == LOCK_W'(1)) begin
                  ack_q <= req_d;
               end
            end
            if (!auto_en_s) begin
               sec_q <= '0;
            end else if (tick_i) begin
               if (sec_q >= period - SEC_W'(1)) begin
                  sec_q   <= '0;
                  apply_q <= 1'b1;
               end else begin
                  sec_q <= sec_q + SEC_W'(1);
               end
            end
         end
      end
   end

   assign ack_o   = ack_q;
   assign adj_o   = adj_q;
   assign apply_o = apply_q;
   assign add_o   = (sign == TRIM_ADD);
   assign sub_o   = (sign == TRIM_SUB);
   assign mag_o   = adj_q[MAG_W-1:0];

   // R8: the register is frozen while the settle window runs
   a_r8_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q != '0 && !sw_rst) |=> $stable(adj_q));
   // R9: soft reset clears the register and the window
   a_r9_sw_rst_clears: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst |=> (adj_q == '0 && lock_q == '0));
   // R6: a trim request is a single-cycle event
   a_r6_apply_single: assert property (@(posedge clk) disable iff (!rst_n)
      apply_q |=> !apply_q);
   // R7: automatic counter never passes the selected period
   a_r7_sec_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      sec_q <= SEC_W'(PER_MAX));
endmodule

// File: rtl/rtc_trim_div.sv
module rtc_trim_div
   import rtc_trim_pkg::*;
#(
   parameter int DIV_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_rst,
   input  logic             apply_i,
   input  logic             add_i,
   input  logic             sub_i,
   input  logic [MAG_W-1:0] mag_i,
   output logic             tick_o
);
   localparam logic [DIV_W:0] DIV_N = (DIV_W + 1)'(1) << DIV_W;

   logic [DIV_W-1:0] cnt_q;
   logic [MAG_W-1:0] stall_q;
   logic             tick_q;
   logic [DIV_W:0]   step;
   logic [DIV_W:0]   sum;
   logic             hold;

   assign step = (apply_i && add_i) ? (DIV_W + 1)'(mag_i) + (DIV_W + 1)'(1)
                                     : (DIV_W + 1)'(1);
   assign sum  = {1'b0, cnt_q} + step;
   assign hold = (stall_q != '0) && !apply_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         stall_q <= '0;
         tick_q  <= 1'b0;
      end else if (sw_rst) begin
         cnt_q   <= '0;
         stall_q <= '0;
         tick_q  <= 1'b0;
      end else begin
         tick_q <= 1'b0;
         if (hold) begin
            stall_q <= stall_q - MAG_W'(1);
         end else begin
            if (sum >= DIV_N) begin
               cnt_q  <= DIV_W'(sum - DIV_N);
               tick_q <= 1'b1;
            end else begin
               cnt_q <= sum[DIV_W-1:0];
            end
            stall_q <= (apply_i && sub_i) ? mag_i : '0;
         end
      end
   end

   assign tick_o = tick_q;

   // R2: the tick is a single-cycle pulse
   a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q |=> !tick_q);
   // R4: the divider does not move while a subtract stall runs
   a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_q != '0 && !apply_i && !sw_rst) |=> ($stable(cnt_q) && !tick_q));
endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
   import rtc_trim_pkg::*;
#(
   parameter int DIV_W       = 15,
   parameter int LOCK_CYC    = 320,
   parameter int AUTO_SHORT  = 10,
   parameter int AUTO_LONG   = 60,
   parameter int SYNC_STAGES = 2
) (
   input  logic       bus_clk,
   input  logic       bus_rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       auto_en,
   input  logic       auto_sel,
   output logic [7:0] rd_data,
   output logic       busy,
   input  logic       src_clk,
   input  logic       src_rst_n,
   input  logic       sw_rst,
   output logic       tick
);
   generate
      if (DIV_W <= MAG_W + 1 || DIV_W > 24) begin : g_bad_div
         $error("rtc_trim_prescaler: DIV_W out of range");
      end
      if (LOCK_CYC < 1) begin : g_bad_lock
         $error("rtc_trim_prescaler: LOCK_CYC must be positive");
      end
      if (AUTO_SHORT < 1 || AUTO_LONG < 1) begin : g_bad_auto
         $error("rtc_trim_prescaler: automatic periods must be positive");
      end
   endgenerate

   logic             req_b;
   logic [REG_W-1:0] data_b;
   logic             ack_s;
   logic             ack_src;
   logic             req_s;
   logic [1:0]       ctl_s;
   logic [REG_W-1:0] adj_src;
   logic             apply;
   logic             add;
   logic             sub;
   logic [MAG_W-1:0] mag;
   logic             tick_int;

   rtc_trim_bus u_bus (
      .clk     (bus_clk),
      .rst_n   (bus_rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .ack_s   (ack_s),
      .req_o   (req_b),
      .data_o  (data_b),
      .busy_o  (busy)
   );

   rtc_trim_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_req_sync (
      .clk (src_clk), .rst_n (src_rst_n), .d (req_b), .q (req_s));

   rtc_trim_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_ctl_sync (
      .clk (src_clk), .rst_n (src_rst_n), .d ({auto_sel, auto_en}), .q (ctl_s));

   rtc_trim_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ack_sync (
      .clk (bus_clk), .rst_n (bus_rst_n), .d (ack_src), .q (ack_s));

   rtc_trim_sync #(.WIDTH(REG_W), .STAGES(SYNC_STAGES)) u_rd_sync (
      .clk (bus_clk), .rst_n (bus_rst_n), .d (adj_src), .q (rd_data));

   rtc_trim_ctl #(
      .LOCK_CYC   (LOCK_CYC),
      .AUTO_SHORT (AUTO_SHORT),
      .AUTO_LONG  (AUTO_LONG)
   ) u_ctl (
      .clk        (src_clk),
      .rst_n      (src_rst_n),
      .sw_rst     (sw_rst),
      .req_s      (req_s),
      .data_i     (data_b),
      .auto_en_s  (ctl_s[0]),
      .auto_sel_s (ctl_s[1]),
      .tick_i     (tick_int),
      .ack_o      (ack_src),
      .adj_o      (adj_src),
      .apply_o    (apply),
      .add_o      (add),
      .sub_o      (sub),
      .mag_o      (mag)
   );

   rtc_trim_div #(.DIV_W(DIV_W)) u_div (
      .clk     (src_clk),
      .rst_n   (src_rst_n),
      .sw_rst  (sw_rst),
      .apply_i (apply),
      .add_i   (add),
      .sub_i   (sub),
      .mag_i   (mag),
      .tick_o  (tick_int)
   );

   assign tick = tick_int;

   // R5: a neutral or prohibited sign never decodes to a direction
   a_r5_one_direction: assert property (@(posedge src_clk) disable iff (!src_rst_n)
      !(add && sub));
endmodule

// File: tb/rtc_trim_prescaler_bench.sv
module rtc_trim_prescaler_bench;
   localparam int DIV_W = 8;
   localparam int NOM   = 1 << DIV_W;
   localparam int LOCK  = 320;
   localparam int PS    = 10;
   localparam int PL    = 20;

   logic       bus_clk = 1'b0;
   logic       src_clk = 1'b0;
   logic       bus_rst_n = 1'b0;
   logic       src_rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       auto_en = 1'b0;
   logic       auto_sel = 1'b0;
   logic       sw_rst = 1'b0;
   logic [7:0] rd_data;
   logic       busy;
   logic       tick;

   always #10 bus_clk = ~bus_clk;
   always #20 src_clk = ~src_clk;

   rtc_trim_prescaler #(
      .DIV_W (DIV_W), .LOCK_CYC (LOCK), .AUTO_SHORT (PS), .AUTO_LONG (PL)
   ) u_rtc_trim_prescaler (
      .bus_clk (bus_clk), .bus_rst_n (bus_rst_n), .wr_en (wr_en),
      .wr_data (wr_data), .auto_en (auto_en), .auto_sel (auto_sel),
      .rd_data (rd_data), .busy (busy), .src_clk (src_clk),
      .src_rst_n (src_rst_n), .sw_rst (sw_rst), .tick (tick)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // scoreboard of expected tick intervals
   int    exp_q[$];
   string tag_q[$];
   event  ev_tick;
   int    cyc = 0;
   int    last_tick = -1;
   bit    rec_en = 0;
   int    rec_n = 0;
   int    rec[64];

   task automatic push(string tag, int v);
      exp_q.push_back(v);
      tag_q.push_back(tag);
   endtask

   always @(negedge src_clk) begin
      cyc++;
      if (tick) begin
         if (last_tick >= 0 && exp_q.size() > 0) begin
            chk(tag_q.pop_front(), cyc - last_tick, exp_q.pop_front());
         end
         if (rec_en && rec_n < 64 && last_tick >= 0) begin
            rec[rec_n] = cyc - last_tick;
            rec_n++;
         end
         last_tick = cyc;
         -> ev_tick;
      end
   end

   task automatic bus_write(logic [7:0] d);
      @(negedge bus_clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge bus_clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge bus_clk);
      repeat (8) @(negedge bus_clk);
   endtask

   task automatic drain();
      while (exp_q.size() > 0) @(ev_tick);
   endtask

   task automatic manual_case(string tag, logic [7:0] d, int first);
      wait_idle();
      @(ev_tick);
      bus_write(d);
      push(tag, first);
      push("R6", NOM);
      push("R6", NOM);
      drain();
      wait_idle();
      chk("R1", int'(rd_data), int'(d));
   endtask

   task automatic auto_record(int n);
      rec_n = 0;
      rec_en = 1;
      while (rec_n < n) @(ev_tick);
      rec_en = 0;
   endtask

   task automatic auto_check(int per, int adj_len);
      int prev = -1;
      int hits = 0;
      for (int i = 0; i < rec_n; i++) begin
         if (rec[i] != NOM) begin
            chk("R7", rec[i], adj_len);
            if (prev >= 0) chk("R7", i - prev, per);
            prev = i;
            hits++;
         end
      end
      n_chk++;
      if (hits < 2) begin
         n_bad++;
         $display("FAIL R7: actual %0d adjusted intervals expected at least 2", hits);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge bus_clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int k;
      int blen;
      repeat (4) @(negedge src_clk);
      bus_rst_n = 1'b1;
      src_rst_n = 1'b1;
      @(negedge bus_clk);
      // reset state
      chk("R9", int'(rd_data), 0);
      chk("R8", int'(busy), 0);
      chk("R2", int'(tick), 0);

      // R2: nominal division
      @(ev_tick);
      push("R2", NOM);
      push("R2", NOM);
      drain();

      // R3: add 12 (sign 01)
      manual_case("R3", 8'h4C, NOM - 12);
      // R4: subtract 10 (sign 10)
      manual_case("R4", 8'h8A, NOM + 10);
      // R4: subtract the largest magnitude
      manual_case("R4", 8'hBF, NOM + 63);
      // R5: prohibited sign 11 and neutral sign 00
      manual_case("R5", 8'hC5, NOM);
      manual_case("R5", 8'h05, NOM);

      // R8: a write while busy is ignored
      wait_idle();
      @(ev_tick);
      bus_write(8'h41);
      chk("R8", int'(busy), 1);
      bus_write(8'h9F);
      push("R8", NOM - 1);
      push("R8", NOM);
      push("R8", NOM);
      blen = 2;
      while (busy) begin
         @(negedge bus_clk);
         blen++;
      end
      n_chk++;
      if (blen < 2 * LOCK) begin
         n_bad++;
         $display("FAIL R8: actual busy %0d bus cycles expected at least %0d", blen, 2 * LOCK);
      end
      drain();
      wait_idle();
      chk("R8", int'(rd_data), 8'h41);

      // R9: soft reset clears and restarts the divider
      wait_idle();
      @(negedge src_clk);
      sw_rst = 1'b1;
      @(negedge src_clk);
      sw_rst = 1'b0;
      k = 0;
      do begin
         @(negedge src_clk);
         k++;
      end while (!tick);
      chk("R9", k, NOM);
      repeat (8) @(negedge bus_clk);
      chk("R9", int'(rd_data), 0);
      chk("R9", int'(busy), 0);

      // R7: automatic, short period, subtract 8
      auto_sel = 1'b0;
      auto_en = 1'b1;
      repeat (3) @(ev_tick);
      bus_write(8'h88);
      auto_record(3 * PS - 5);
      auto_check(PS, NOM + 8);
      wait_idle();
      chk("R7", int'(rd_data), 8'h88);

      // R7: automatic, long period
      auto_en = 1'b0;
      repeat (2) @(ev_tick);
      auto_sel = 1'b1;
      auto_en = 1'b1;
      auto_record(2 * PL + 5);
      auto_check(PL, NOM + 8);

      finish_run();
   end
endmodule